// File: doc/BRIEF.md
# Pixel Matrix Power-Pulsing Sleep/Wake Controller

This block sits in the periphery of a pixel readout chip and switches the static analog power of the pixel matrix on and off in step with an external pulse. One input pad carries the sleep command. A high level asks the chip to sleep and a low level asks it to wake. The pad drives the block directly, so no software command sequence is involved. The pad level is brought into the clock domain through two flops and must hold steady for a set number of cycles before it is acted on.

Two configuration values choose what takes part in a sleep cycle. A column pattern marks the pixel columns whose sleep devices are switched. A DAC mask marks the bias DACs whose outputs are gated. Unmarked columns and DACs stay powered at all times. Each column is driven by an active-high enable for its ground-side NMOS device and an active-low enable for its supply-side PMOS device. A four-state sequencer (awake, entering sleep, asleep, waking) sets the sleep-done and ready flags from two settling counts. The count after a sleep command is short and the count after a wake command is long, because the analog circuits need far longer to become usable again.

Top module: `pwr_pulse_ctrl`

## Requirements
- R1: After reset the block is awake: every column NMOS enable is 1, every PMOS enable is 0, every DAC enable is 1, ready is 1 and sleep-done is 0. The column pattern and DAC mask reset to all ones.
- R2: The pad passes through two synchronizing flops. A new level takes effect only after it has been seen for DEBOUNCE_CYCLES consecutive cycles, so a pad change acts on the enables 7 clock edges after it is first sampled. Shorter pulses have no effect.
- R3: When a debounced sleep command arrives in the awake state, ready falls and the selected enables drop in the same cycle.
- R4: For every column c and in every cycle, the PMOS enable (active low) equals the inverse of the NMOS enable (active high).
- R5: While entering sleep or asleep, dac_en_o[i] is 0 when mask bit i is 1 and stays 1 when mask bit i is 0.
- R6: While entering sleep or asleep, column c is switched off (NMOS enable 0) when pattern bit c is 1 and stays on when pattern bit c is 0.
- R7: Sleep-done rises SLEEP_SETTLE_CYCLES cycles after sleep entry begins and stays high until a wake command arrives.
- R8: When a debounced wake command arrives, all enables return to on in the same cycle. Ready rises WAKE_SETTLE_CYCLES cycles later.
- R9: A wake command seen while still entering sleep moves straight to waking, and sleep-done never rises. This holds on the last settling cycle too.
- R10: A sleep command seen while waking returns to entering sleep. Ready stays low, and sleep-done rises after the sleep settling count.
- R11: A configuration write takes effect only when the block is awake and stays awake in that cycle. A write at any other time is held, the newest write winning, and is applied once the block is awake and idle. Until then it changes no enable.
- R12: Ready and sleep-done are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pad_sleep_i | input | 1 | Asynchronous sleep command pad, 1 = sleep, 0 = wake |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_dac_mask_i | input | NUM_DACS | DAC participation mask written on cfg_we_i |
| cfg_col_pat_i | input | NUM_COLS | Column sleep pattern written on cfg_we_i |
| col_footer_en_o | output | NUM_COLS | Per-column NMOS sleep device enable, active high |
| col_header_en_n_o | output | NUM_COLS | Per-column PMOS sleep device enable, active low |
| dac_en_o | output | NUM_DACS | Per-DAC output gate enable, 1 = powered |
| ready_o | output | 1 | Analog matrix usable (awake and settled) |
| sleep_done_o | output | 1 | Sleep settling finished |

## Verification
The assertions compare the applied pattern and mask with the enables only in the asleep state. This relies on the configuration being stable at that point, which the hold-until-idle rule guarantees. The checks also take the pad to be a level command that may glitch but does not toggle faster than the debounce window once a transition is meant. The stimulus follows that rule. Every intended pad change is held for at least four cycles. The only shorter pulse is the deliberate two-cycle glitch, and it is applied while the block is awake with nothing in flight. Configuration writes are single-cycle strobes, made either while idle or while asleep.

// File: rtl/pp_pkg.sv
package pp_pkg;
    typedef enum logic [1:0] {
        PP_AWAKE  = 2'd0,
        PP_ENTER  = 2'd1,
        PP_ASLEEP = 2'd2,
        PP_WAKING = 2'd3
    } pp_state_e;
endpackage

// File: rtl/pp_pad_filter.sv
// Two-flop synchronizer followed by a consecutive-cycle debounce.
module pp_pad_filter #(
    parameter int DEB_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pad_i,
    output logic level_o
);
    localparam int CW = $clog2(DEB_CYCLES) + 1;

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic          filt;
        logic [CW-1:0] cnt;
    } flt_t;

    flt_t flt_d, flt_q;

    always_comb begin
        flt_d    = flt_q;
        flt_d.s1 = pad_i;
        flt_d.s2 = flt_q.s1;
        if (flt_q.s2 == flt_q.filt) begin
            flt_d.cnt = '0;
        end else if (flt_q.cnt == CW'(DEB_CYCLES - 1)) begin
            flt_d.filt = flt_q.s2;
            flt_d.cnt  = '0;
        end else begin
            flt_d.cnt = flt_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flt_q <= '0;
        else        flt_q <= flt_d;
    end

    assign level_o = flt_q.filt;
endmodule

// File: rtl/pp_fsm.sv
// Sleep/wake sequencer with settling counters.
module pp_fsm
    import pp_pkg::*;
#(
    parameter int SLEEP_CYCLES = 4,
    parameter int WAKE_CYCLES  = 80
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sleep_req_i,
    output pp_state_e state_o,
    output pp_state_e state_nxt_o,
    output logic      gate_nxt_o,
    output logic      ready_o,
    output logic      sleep_done_o
);
    localparam int MAXC = (WAKE_CYCLES > SLEEP_CYCLES) ? WAKE_CYCLES : SLEEP_CYCLES;
    localparam int CW   = $clog2(MAXC + 1);

    typedef struct packed {
        pp_state_e     st;
        logic [CW-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.st)
            PP_AWAKE: begin
                if (sleep_req_i) begin
                    seq_d.st  = PP_ENTER;
                    seq_d.cnt = '0;
                end
            end
            PP_ENTER: begin
                if (!sleep_req_i) begin
                    seq_d.st  = PP_WAKING;
                    seq_d.cnt = '0;
                end else if (seq_q.cnt == CW'(SLEEP_CYCLES - 1)) begin
                    seq_d.st  = PP_ASLEEP;
                    seq_d.cnt = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + CW'(1);
                end
            end
            PP_ASLEEP: begin
                if (!sleep_req_i) begin
                    seq_d.st  = PP_WAKING;
                    seq_d.cnt = '0;
                end
            end
            PP_WAKING: begin
                if (sleep_req_i) begin
                    seq_d.st  = PP_ENTER;
                    seq_d.cnt = '0;
                end else if (seq_q.cnt == CW'(WAKE_CYCLES - 1)) begin
                    seq_d.st  = PP_AWAKE;
                    seq_d.cnt = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + CW'(1);
                end
            end
            default: seq_d = '{st: PP_AWAKE, cnt: '0};
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{st: PP_AWAKE, cnt: '0};
        else        seq_q <= seq_d;
    end

    assign state_o      = seq_q.st;
    assign state_nxt_o  = seq_d.st;
    assign gate_nxt_o   = (seq_d.st == PP_ENTER) || (seq_d.st == PP_ASLEEP);
    assign ready_o      = (seq_q.st == PP_AWAKE);
    assign sleep_done_o = (seq_q.st == PP_ASLEEP);
endmodule

// File: rtl/pp_cfg_hold.sv
// Holds configuration writes until the sequencer is awake and idle.
module pp_cfg_hold
    import pp_pkg::*;
#(
    parameter int NC = 8,
    parameter int ND = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [ND-1:0] mask_i,
    input  logic [NC-1:0] pat_i,
    input  pp_state_e     state_i,
    input  pp_state_e     state_nxt_i,
    output logic [ND-1:0] mask_o,
    output logic [NC-1:0] pat_o
);
    typedef struct packed {
        logic [ND-1:0] mask;
        logic [NC-1:0] pat;
        logic          pend_v;
        logic [ND-1:0] pend_mask;
        logic [NC-1:0] pend_pat;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic idle;

    assign idle = (state_i == PP_AWAKE) && (state_nxt_i == PP_AWAKE);

    always_comb begin
        cfg_d = cfg_q;
        if (idle) begin
            if (we_i) begin
                cfg_d.mask   = mask_i;
                cfg_d.pat    = pat_i;
                cfg_d.pend_v = 1'b0;
            end else if (cfg_q.pend_v) begin
                cfg_d.mask   = cfg_q.pend_mask;
                cfg_d.pat    = cfg_q.pend_pat;
                cfg_d.pend_v = 1'b0;
            end
        end else if (we_i) begin
            cfg_d.pend_v    = 1'b1;
            cfg_d.pend_mask = mask_i;
            cfg_d.pend_pat  = pat_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '{mask: '1, pat: '1, pend_v: 1'b0, pend_mask: '0, pend_pat: '0};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign mask_o = cfg_q.mask;
    assign pat_o  = cfg_q.pat;
endmodule

// File: rtl/pp_gate_drv.sv
// Registered per-column complementary sleep enables and per-DAC gates.
module pp_gate_drv #(
    parameter int NC = 8,
    parameter int ND = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          gate_nxt_i,
    input  logic [ND-1:0] mask_i,
    input  logic [NC-1:0] pat_i,
    output logic [NC-1:0] footer_o,
    output logic [NC-1:0] header_n_o,
    output logic [ND-1:0] dac_o
);
    typedef struct packed {
        logic [NC-1:0] foot;
        logic [ND-1:0] dac;
    } drv_t;

    drv_t drv_d, drv_q;
    logic [NC-1:0] foot_nxt;
    logic [ND-1:0] dac_nxt;

    for (genvar c = 0; c < NC; c++) begin : g_col
        assign foot_nxt[c] = !(gate_nxt_i && pat_i[c]);
    end

    for (genvar i = 0; i < ND; i++) begin : g_dac
        assign dac_nxt[i] = !(gate_nxt_i && mask_i[i]);
    end

    always_comb begin
        drv_d      = drv_q;
        drv_d.foot = foot_nxt;
        drv_d.dac  = dac_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) drv_q <= '{foot: '1, dac: '1};
        else        drv_q <= drv_d;
    end

    assign footer_o   = drv_q.foot;
    assign header_n_o = ~drv_q.foot;
    assign dac_o      = drv_q.dac;
endmodule

// File: rtl/pwr_pulse_ctrl.sv
module pwr_pulse_ctrl
    import pp_pkg::*;
#(
    parameter int NUM_COLS            = 8,
    parameter int NUM_DACS            = 4,
    parameter int DEBOUNCE_CYCLES     = 4,
    parameter int SLEEP_SETTLE_CYCLES = 4,
    parameter int WAKE_SETTLE_CYCLES  = 80
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pad_sleep_i,
    input  logic                cfg_we_i,
    input  logic [NUM_DACS-1:0] cfg_dac_mask_i,
    input  logic [NUM_COLS-1:0] cfg_col_pat_i,
    output logic [NUM_COLS-1:0] col_footer_en_o,
    output logic [NUM_COLS-1:0] col_header_en_n_o,
    output logic [NUM_DACS-1:0] dac_en_o,
    output logic                ready_o,
    output logic                sleep_done_o
);
    logic                sleep_req;
    pp_state_e           state_q;
    pp_state_e           state_nxt;
    logic                gate_nxt;
    logic [NUM_DACS-1:0] mask_q;
    logic [NUM_COLS-1:0] pat_q;

    pp_pad_filter #(.DEB_CYCLES(DEBOUNCE_CYCLES)) i_pad (
        .clk     (clk),
        .rst_n   (rst_n),
        .pad_i   (pad_sleep_i),
        .level_o (sleep_req)
    );

    pp_fsm #(
        .SLEEP_CYCLES (SLEEP_SETTLE_CYCLES),
        .WAKE_CYCLES  (WAKE_SETTLE_CYCLES)
    ) i_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .sleep_req_i  (sleep_req),
        .state_o      (state_q),
        .state_nxt_o  (state_nxt),
        .gate_nxt_o   (gate_nxt),
        .ready_o      (ready_o),
        .sleep_done_o (sleep_done_o)
    );

    pp_cfg_hold #(.NC(NUM_COLS), .ND(NUM_DACS)) i_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .we_i        (cfg_we_i),
        .mask_i      (cfg_dac_mask_i),
        .pat_i       (cfg_col_pat_i),
        .state_i     (state_q),
        .state_nxt_i (state_nxt),
        .mask_o      (mask_q),
        .pat_o       (pat_q)
    );

    pp_gate_drv #(.NC(NUM_COLS), .ND(NUM_DACS)) i_drv (
        .clk        (clk),
        .rst_n      (rst_n),
        .gate_nxt_i (gate_nxt),
        .mask_i     (mask_q),
        .pat_i      (pat_q),
        .footer_o   (col_footer_en_o),
        .header_n_o (col_header_en_n_o),
        .dac_o      (dac_en_o)
    );
endmodule

// File: rtl/pp_chk.sv
module pp_chk
    import pp_pkg::*;
#(
    parameter int NC = 8,
    parameter int ND = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic [NC-1:0] footer,
    input logic [NC-1:0] header_n,
    input logic [ND-1:0] dac,
    input logic          ready,
    input logic          done,
    input pp_state_e     state,
    input logic [ND-1:0] mask,
    input logic [NC-1:0] pat
);
    // R4
    compl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        header_n == ~footer);

    // R12
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ready && done));

    // R6
    col_pat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PP_ASLEEP) |-> (footer == ~pat));

    // R5
    dac_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PP_ASLEEP) |-> (dac == ~mask));

    // R8
    awake_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PP_AWAKE || state == PP_WAKING) |-> ((&footer) && (&dac)));

    // R7
    done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(state) == PP_ENTER));

    // R8
    ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> ($past(state) == PP_WAKING));

    // R11
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !($stable(pat) && $stable(mask)) |-> ($past(state) == PP_AWAKE));
endmodule

bind pwr_pulse_ctrl pp_chk #(.NC(NUM_COLS), .ND(NUM_DACS)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .footer   (col_footer_en_o),
    .header_n (col_header_en_n_o),
    .dac      (dac_en_o),
    .ready    (ready_o),
    .done     (sleep_done_o),
    .state    (state_q),
    .mask     (mask_q),
    .pat      (pat_q)
);

// File: tb/test_pwr_pulse_ctrl.sv
module test_pwr_pulse_ctrl;
    localparam int NC   = 8;
    localparam int ND   = 4;
    localparam int LAT  = 7;
    localparam int SLP  = 4;
    localparam int WAK  = 80;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pad = 1'b0;
    logic          we = 1'b0;
    logic [ND-1:0] mask_in = '0;
    logic [NC-1:0] pat_in = '0;
    logic [NC-1:0] footer;
    logic [NC-1:0] header_n;
    logic [ND-1:0] dac;
    logic          ready;
    logic          done;

    int cyc = 0;
    int vectors = 0;
    int fails = 0;
    bit finished = 1'b0;

    typedef struct {
        int            when;
        string         tag;
        logic [NC-1:0] fo;
        logic [ND-1:0] da;
        logic          rd;
        logic          dn;
    } item_t;

    item_t sb[$];

    localparam logic [NC-1:0] ON_C = '1;
    localparam logic [ND-1:0] ON_D = '1;

    pwr_pulse_ctrl #(
        .NUM_COLS(NC), .NUM_DACS(ND), .DEBOUNCE_CYCLES(4),
        .SLEEP_SETTLE_CYCLES(SLP), .WAKE_SETTLE_CYCLES(WAK)
    ) i_pwr_pulse_ctrl (
        .clk(clk), .rst_n(rst_n), .pad_sleep_i(pad), .cfg_we_i(we),
        .cfg_dac_mask_i(mask_in), .cfg_col_pat_i(pat_in),
        .col_footer_en_o(footer), .col_header_en_n_o(header_n),
        .dac_en_o(dac), .ready_o(ready), .sleep_done_o(done)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic push(input int w, input string t, input logic [NC-1:0] f,
                        input logic [ND-1:0] d, input logic r, input logic n);
        sb.push_back('{w, t, f, d, r, n});
    endtask

    task automatic wait_to(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    // Monitor: pop expected items as their cycle arrives.
    always @(negedge clk) begin : mon
        item_t it;
        if (rst_n) begin
            while (sb.size() > 0 && sb[0].when <= cyc) begin
                it = sb.pop_front();
                vectors++;
                if (it.when != cyc || footer != it.fo || header_n != ~it.fo ||
                    dac != it.da || ready != it.rd || done != it.dn) begin
                    fails++;
                    $display("FAIL %s cyc=%0d: act foot=%b hdr_n=%b dac=%b rdy=%b done=%b exp foot=%b hdr_n=%b dac=%b rdy=%b done=%b (due %0d)",
                             it.tag, cyc, footer, header_n, dac, ready, done,
                             it.fo, ~it.fo, it.da, it.rd, it.dn, it.when);
                end
            end
        end
    end

    task automatic finish_run();
        if (sb.size() > 0) begin
            fails += sb.size();
            $display("FAIL scoreboard: act %0d items left, exp 0", sb.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: act timeout, exp completion");
            finish_run();
        end
    end

    initial begin : drive
        int n;
        int m;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        vectors++;
        if (footer !== ON_C || header_n !== '0 || dac !== ON_D || ready !== 1'b1 || done !== 1'b0) begin
            fails++;
            $display("FAIL R1: act foot=%b hdr_n=%b dac=%b rdy=%b done=%b exp all on, rdy=1 done=0",
                     footer, header_n, dac, ready, done);
        end

        // R3 / R7: sleep with default config (all columns and DACs)
        wait_to(3);
        n = cyc; pad = 1'b1;
        push(n+LAT-1, "R2", ON_C, ON_D, 1, 0);
        push(n+LAT, "R3", '0, '0, 0, 0);
        push(n+LAT+SLP-1, "R7", '0, '0, 0, 0);
        push(n+LAT+SLP, "R7", '0, '0, 0, 1);
        wait_to(n+20);

        // R8: wake
        m = cyc; pad = 1'b0;
        push(m+LAT-1, "R8", '0, '0, 0, 1);
        push(m+LAT, "R8", ON_C, ON_D, 0, 0);
        push(m+LAT+WAK-1, "R8", ON_C, ON_D, 0, 0);
        push(m+LAT+WAK, "R8", ON_C, ON_D, 1, 0);
        wait_to(m+LAT+WAK+8);

        // R11: idle write applied immediately
        n = cyc; we = 1'b1; mask_in = 4'b0101; pat_in = 8'hA3;
        @(negedge clk); we = 1'b0;
        push(n+3, "R11", ON_C, ON_D, 1, 0);
        wait_to(n+5);

        // R5 / R6: partial gating
        n = cyc; pad = 1'b1;
        push(n+LAT, "R6", 8'h5C, 4'b1010, 0, 0);
        push(n+LAT+SLP, "R5", 8'h5C, 4'b1010, 0, 1);
        wait_to(n+LAT+SLP+4);

        // R11: write while asleep is held, no output change
        n = cyc; we = 1'b1; mask_in = 4'b1111; pat_in = 8'h0F;
        @(negedge clk); we = 1'b0;
        push(n+3, "R11", 8'h5C, 4'b1010, 0, 1);
        wait_to(n+10);
        m = cyc; pad = 1'b0;
        push(m+LAT, "R8", ON_C, ON_D, 0, 0);
        push(m+LAT+WAK, "R8", ON_C, ON_D, 1, 0);
        wait_to(m+LAT+WAK+4);

        // R11: held write now in effect
        n = cyc; pad = 1'b1;
        push(n+LAT, "R11", 8'hF0, 4'b0000, 0, 0);
        push(n+LAT+SLP, "R11", 8'hF0, 4'b0000, 0, 1);
        wait_to(n+LAT+SLP+4);
        m = cyc; pad = 1'b0;
        push(m+LAT+WAK, "R8", ON_C, ON_D, 1, 0);
        wait_to(m+LAT+WAK+4);

        // R2: two-cycle glitch ignored
        n = cyc; pad = 1'b1;
        @(negedge clk); @(negedge clk); pad = 1'b0;
        push(n+6, "R2", ON_C, ON_D, 1, 0);
        push(n+9, "R2", ON_C, ON_D, 1, 0);
        push(n+14, "R2", ON_C, ON_D, 1, 0);
        wait_to(n+20);

        // R9: wake on the last entering cycle
        n = cyc; pad = 1'b1;
        wait_to(n+4); pad = 1'b0;
        push(n+LAT, "R9", 8'hF0, 4'b0000, 0, 0);
        push(n+LAT+SLP-1, "R9", 8'hF0, 4'b0000, 0, 0);
        push(n+LAT+SLP, "R9", ON_C, ON_D, 0, 0);
        push(n+LAT+SLP+1, "R9", ON_C, ON_D, 0, 0);
        push(n+LAT+SLP+WAK-1, "R9", ON_C, ON_D, 0, 0);
        push(n+LAT+SLP+WAK, "R9", ON_C, ON_D, 1, 0);
        wait_to(n+LAT+SLP+WAK+4);

        // R10: sleep during waking
        n = cyc; pad = 1'b1;
        wait_to(n+LAT+SLP+4);
        m = cyc; pad = 1'b0;
        wait_to(m+20); pad = 1'b1;
        push(m+20+LAT-1, "R10", ON_C, ON_D, 0, 0);
        push(m+20+LAT, "R10", 8'hF0, 4'b0000, 0, 0);
        push(m+20+LAT+SLP, "R10", 8'hF0, 4'b0000, 0, 1);
        wait_to(m+20+LAT+SLP+4);
        m = cyc; pad = 1'b0;
        push(m+LAT+WAK, "R12", ON_C, ON_D, 1, 0);
        wait_to(m+LAT+WAK+4);

        finished = 1'b1;
        finish_run();
    end
endmodule